// File: doc/BRIEF.md
# Address Bus Grant Qualifier

This block is the master-side half of address-bus arbitration on a pipelined, split-transaction bus that is shared through an external central arbiter. The core queues address tenures with a one-cycle push strobe. While any queued tenure is not yet on the bus, the block holds an active-low request to the arbiter. Each cycle it decides whether the arbiter's grant is usable. A grant is usable only when all of the following hold: no other master is starting a transfer, the address retry line has been quiet for two cycles in a row, and this block is not already the address owner.

When it takes a grant, the block pulses its own transfer-start line for one cycle. It drives an active-low address-busy output until the address is acknowledged, and then reports the tenure as complete. A retry during the tenure ends ownership without completing it, and the tenure goes back into the queue for re-arbitration. When the arbiter has parked the bus on this master, a qualified grant is taken at once, even if no request was ever raised. The address-busy line is only driven by this block. The board pulls it high, so it reads idle when nobody owns the bus.

Top module: `addr_grant_qual`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bus_req_n`, `ts_out_n` and `abb_n` are 1 and `tenure_done` is 0.
- R2: One cycle after a tenure is queued and is not on the bus, `bus_req_n` is 0. It stays 0 until every queued tenure is either on the bus or complete.
- R3: A grant is qualified only if, in the same cycle, `bus_gnt_n`=0, `aretry_n`=1, `aretry_n` was 1 in the previous cycle, `ts_in_n`=1, and the block is not the address owner. Without a qualified grant, no tenure starts.
- R4: When `parked`=0, a qualified grant starts a tenure only if `bus_req_n` is already 0 in that cycle.
- R5: When `parked`=1, a qualified grant starts a tenure if any tenure is queued, including one pushed in the same cycle, whatever the state of `bus_req_n`.
- R6: A tenure start drives `ts_out_n` to 0 for exactly one cycle, in the cycle after the qualified grant. `abb_n` goes to 0 in that same cycle.
- R7: `abb_n` stays 0 until `aack_n`=0 is sampled with `aretry_n`=1. In the next cycle `abb_n` is 1 and `tenure_done` pulses to 1 for one cycle.
- R8: If `aretry_n`=0 is sampled while the block owns the bus, `abb_n` is 1 in the next cycle and no completion is reported. The tenure stays queued, and `bus_req_n` is 0 again.
- R9: In the cycle after a tenure start, `bus_req_n` is 1 unless another queued tenure is still waiting for the bus.
- R10: A push while `MAX_PEND` tenures are already queued is ignored. Draining the queue then yields exactly `MAX_PEND` completions.
- R11: When retry and acknowledge are sampled together during a tenure, retry wins. There is no completion, and the tenure is requeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tenure_push | input | 1 | One-cycle strobe that queues an address tenure |
| parked | input | 1 | 1 when the arbiter has parked the address bus on this master |
| bus_gnt_n | input | 1 | Address bus grant from the arbiter, active low |
| aretry_n | input | 1 | Address retry line, active low |
| ts_in_n | input | 1 | Transfer start seen on the bus from another master, active low |
| aack_n | input | 1 | Address acknowledge, active low |
| bus_req_n | output | 1 | Address bus request to the arbiter, active low |
| ts_out_n | output | 1 | Transfer start driven by this master, active low |
| abb_n | output | 1 | Address bus busy, active low, output only |
| tenure_done | output | 1 | One-cycle pulse when an owned tenure is acknowledged |

## Verification
The bench covers several corner cases:
- A retry that clears one cycle before a grant. A design that checks only the current retry value starts one cycle early.
- A parked grant in the same cycle as the first push. A design that waits for its own request loses that cycle and raises a needless request.
- Retry and acknowledge arriving together. A design that favours the acknowledge drops a tenure the bus has refused.
- Pushes into a full queue. A design that wraps its count produces the wrong number of completions.

Long constrained-random runs then check the request line after each start. A design that forgets queued work would leave the request high while tenures are still waiting.

// File: rtl/agq_pkg.sv
package agq_pkg;
  typedef enum logic {
    OWN_IDLE = 1'b0,
    OWN_BUSY = 1'b1
  } own_e;

  typedef struct packed {
    logic gnt;
    logic rty;
    logic tsin;
    logic ack;
  } bus_smp_t;
endpackage

// File: rtl/agq_retry_hist.sv
module agq_retry_hist #(
  parameter int HIST = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic rty_now,
  output logic rty_recent
);
  logic [HIST-1:0] stage_q;

  generate
    for (genvar i = 0; i < HIST; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= rty_now;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[i] <= 1'b0;
          else     stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign rty_recent = |stage_q;
endmodule

// File: rtl/agq_qualifier.sv
module agq_qualifier
  import agq_pkg::*;
(
  input  bus_smp_t smp,
  input  logic     rty_recent,
  input  logic     owner,
  output logic     qual
);
  always_comb begin
    qual = smp.gnt && !smp.rty && !rty_recent && !smp.tsin && !owner;
  end
endmodule

// File: rtl/agq_tenure.sv
module agq_tenure
  import agq_pkg::*;
#(
  parameter int MAX_PEND = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  logic     parked,
  input  logic     qual,
  input  bus_smp_t smp,
  output logic     owner,
  output logic     req_n,
  output logic     ts_n,
  output logic     done
);
  localparam int CW = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0] FULL = CW'(MAX_PEND);

  logic [CW-1:0] pend_q, pend_d;
  own_e          own_q, own_d;
  logic          push_ok, start, end_rty, end_ack, work_now;

  assign owner = (own_q == OWN_BUSY);

  always_comb begin
    push_ok  = push && (pend_q != FULL);
    work_now = (pend_q != '0) || push_ok;
    start    = qual && (parked ? work_now : !req_n);
    end_rty  = owner && smp.rty;
    end_ack  = owner && !smp.rty && smp.ack;
    pend_d   = pend_q + CW'(push_ok) - CW'(end_ack);
    own_d    = own_q;
    if (start)                own_d = OWN_BUSY;
    else if (end_rty || end_ack) own_d = OWN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      own_q  <= OWN_IDLE;
      req_n  <= 1'b1;
      ts_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      own_q  <= own_d;
      req_n  <= !(pend_d > CW'(own_d == OWN_BUSY));
      ts_n   <= !start;
      done   <= end_ack;
    end
  end

  // R6
  ts_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_n |=> ts_n);
  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (owner && smp.ack && !smp.rty) |=> (!owner && done));
  // R11
  retry_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (owner && smp.rty) |=> (!owner && !done));
endmodule

// File: rtl/addr_grant_qual.sv
module addr_grant_qual
  import agq_pkg::*;
#(
  parameter int MAX_PEND = 4,
  parameter int RTY_HIST = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic tenure_push,
  input  logic parked,
  input  logic bus_gnt_n,
  input  logic aretry_n,
  input  logic ts_in_n,
  input  logic aack_n,
  output logic bus_req_n,
  output logic ts_out_n,
  output logic abb_n,
  output logic tenure_done
);
  bus_smp_t smp;
  logic     rty_recent, owner, qual;

  always_comb begin
    smp.gnt  = !bus_gnt_n;
    smp.rty  = !aretry_n;
    smp.tsin = !ts_in_n;
    smp.ack  = !aack_n;
  end

  agq_retry_hist #(.HIST(RTY_HIST)) u_hist (
    .clk(clk), .rst(rst), .rty_now(smp.rty), .rty_recent(rty_recent)
  );

  agq_qualifier u_qual (
    .smp(smp), .rty_recent(rty_recent), .owner(owner), .qual(qual)
  );

  agq_tenure #(.MAX_PEND(MAX_PEND)) u_ten (
    .clk(clk), .rst(rst), .push(tenure_push), .parked(parked),
    .qual(qual), .smp(smp), .owner(owner), .req_n(bus_req_n),
    .ts_n(ts_out_n), .done(tenure_done)
  );

  assign abb_n = !owner;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (bus_req_n && ts_out_n && abb_n && !tenure_done));
  // R3
  start_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ts_out_n) |-> ($past(!bus_gnt_n) && $past(aretry_n) && $past(ts_in_n) && $past(abb_n)));
  // R4
  unparked_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ts_out_n) && !$past(parked)) |-> $past(!bus_req_n));
  // R6
  ts_with_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_out_n |-> !abb_n);
endmodule

// File: tb/sim_addr_grant_qual.sv
module sim_addr_grant_qual;
  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0, parked = 1'b0;
  logic gnt_n = 1'b1, rty_n = 1'b1, tsin_n = 1'b1, aack_n = 1'b1;
  logic req_n, ts_n, abb_n, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  int  m_pend = 0;
  bit  m_own = 0, m_rty1 = 0, m_req = 0, m_ts = 0, m_done = 0;

  always #2 clk = ~clk;

  addr_grant_qual #(.MAX_PEND(MAXP), .RTY_HIST(1)) u0 (
    .clk(clk), .rst(rst), .tenure_push(push), .parked(parked),
    .bus_gnt_n(gnt_n), .aretry_n(rty_n), .ts_in_n(tsin_n), .aack_n(aack_n),
    .bus_req_n(req_n), .ts_out_n(ts_n), .abb_n(abb_n), .tenure_done(done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected next state from the requirements (R2..R11)
  task automatic model_step(input bit p, pk, g, r, t, a);
    bit qual, push_ok, start, end_ack;
    push_ok = p && (m_pend < MAXP);                       // R10
    qual    = g && !r && !m_rty1 && !t && !m_own;         // R3
    start   = qual && (pk ? (m_pend > 0 || push_ok) : m_req); // R4 R5
    end_ack = m_own && !r && a;                           // R7 R11
    m_pend  = m_pend + int'(push_ok) - int'(end_ack);
    m_own   = start || (m_own && !r && !a);               // R8
    m_ts    = start;                                      // R6
    m_done  = end_ack;
    m_req   = (m_pend > int'(m_own));                     // R2 R9
    m_rty1  = r;
  endtask

  task automatic compare();
    chk("R2/R9 bus_req_n", req_n, !m_req);
    chk("R6 ts_out_n", ts_n, !m_ts);
    chk("R7/R8 abb_n", abb_n, !m_own);
    chk("R7 tenure_done", done, m_done);
  endtask

  task automatic cyc(input bit p, pk, g, r, t, a);
    @(negedge clk);
    push = p; parked = pk; gnt_n = !g; rty_n = !r; tsin_n = !t; aack_n = !a;
    @(posedge clk); #1;
    model_step(p, pk, g, r, t, a);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    int dones;
    void'($urandom(32'h5eed_0a1b));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 bus_req_n in reset", req_n, 1'b1);
    chk("R1 ts_out_n in reset", ts_n, 1'b1);
    chk("R1 abb_n in reset", abb_n, 1'b1);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 bus_req_n after reset", req_n, 1'b1);
    chk("R1 abb_n after reset", abb_n, 1'b1);
    chk("R1 tenure_done after reset", done, 1'b0);

    // R4: unparked push with grant the same cycle does not start
    cyc(1, 0, 1, 0, 0, 0);
    chk("R4 no start without request", ts_n, 1'b1);
    chk("R2 request raised", req_n, 1'b0);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R6 start pulse", ts_n, 1'b0);
    chk("R9 request dropped", req_n, 1'b1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 start pulse single", ts_n, 1'b1);
    chk("R7 busy held", abb_n, 1'b0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 release on ack", abb_n, 1'b1);
    chk("R7 done pulse", done, 1'b1);
    idle(2);

    // R5: parked grant taken in the push cycle, no request raised
    cyc(1, 1, 1, 0, 0, 0);
    chk("R5 parked start", ts_n, 1'b0);
    chk("R5 no request while parked", req_n, 1'b1);
    // R11: retry plus ack together -> requeue
    cyc(0, 1, 0, 1, 0, 1);
    chk("R11 ownership ends", abb_n, 1'b1);
    chk("R11 no completion", done, 1'b0);
    chk("R8 request again", req_n, 1'b0);
    // R3: retry seen last cycle blocks the grant
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 previous retry blocks", ts_n, 1'b1);
    cyc(0, 0, 1, 0, 1, 0);
    chk("R3 foreign start blocks", ts_n, 1'b1);
    cyc(0, 0, 1, 0, 0, 0);
    chk("R3 clean grant starts", ts_n, 1'b0);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R7 done after requeue", done, 1'b1);
    idle(2);

    // R10: overfill then drain
    for (int i = 0; i < MAXP + 3; i++) cyc(1, 0, 0, 0, 0, 0);
    dones = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(0, 0, 1, 0, 0, 1);
      if (done) dones++;
    end
    n_chk++;
    if (dones != MAXP) begin
      n_fail++;
      $display("FAIL R10 completions: actual=%0d expected=%0d", dones, MAXP);
    end
    chk("R10 queue empty", req_n, 1'b1);

    // Random mix, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      bit pk;
      pk = ((i / 200) % 2) == 1;
      cyc(($urandom % 5) == 0, pk, ($urandom % 10) < 7, ($urandom % 10) == 0,
          ($urandom % 10) == 0, ($urandom % 10) < 3);
    end
    summary();
  end
endmodule